// File: doc/BRIEF.md
# Program Fetch Bank Gate

This block sits in front of a graphics coprocessor's instruction fetch. When the host asks the coprocessor to run, the block first decides whether execution may begin at the requested 8-bit program bank and 16-bit program counter. The decision is based on three things: whether the counter lies inside the active instruction cache, which memory region the bank falls in, and which external memories the coprocessor currently owns. If the start is refused, the block raises a one-cycle request to clear the run flag in the status register.

During the same evaluation, the block translates the bank number into a physical page in ROM or work RAM. It outputs the full physical address together with a flag that selects the RAM. The numbers of ROM and RAM banks fitted on the cartridge are fixed at build time by parameters, so every modulo in the mapping reduces to a constant lookup.

An evaluation is requested by a one-cycle `startPulse`. All results are registered and appear on the following cycle, marked by `evalDone`. They then hold until the next request.

Top module: `pfbGate`

## Requirements
- R1: When `cacheHit` is high at a start request, the start is valid whatever the bank, counter or enable bits.
- R2: Without a cache hit, a start is invalid in any of these cases: the bank is below 0x40 and the counter is below 0x8000; the bank is in 0x60..0x6F; the bank is 0x74 or higher (this includes all banks with bit 7 set).
- R3: Banks 0x70..0x73 are RAM. Without a cache hit, a start there is valid only when `ramEnable` is high. The address of such a start is flagged with `selRam` = 1.
- R4: Every bank not covered by R2 or R3 is ROM. Without a cache hit, a start there is valid only when `romEnable` is high. Every bank outside 0x70..0x73 yields `selRam` = 0.
- R5: `goClear` is high for exactly the one cycle after a start request whose result is invalid. It stays low after valid starts and when no request is made.
- R6: `startValid`, `physAddr` and `selRam` update only in the cycle after `startPulse` (`evalDone` high in that cycle only). Otherwise they hold, and back-to-back requests each update them. `physAddr[15:0]` equals the requested counter.
- R7: For ROM mapping, let b = bank bits [6:0]. When b >= 0x40, the page `physAddr[22:16]` is b mod N for N > 1, and b & 1 for N <= 1. Here N is the effective ROM bank count.
- R8: For ROM mapping with b < 0x40, the page is (b mod 2N) + 0x20.
- R9: For RAM bank k = bank bits [1:0], the page is k mod `RAM_BANKS`.
- R10: The effective ROM bank count N is `ROM_BANKS` limited to 32.
- R11: After reset, `startValid`, `goClear`, `evalDone`, `selRam` and `physAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to evaluate a start |
| progBank | input | 8 | Program bank number |
| progCounter | input | 16 | Program counter |
| cacheHit | input | 1 | Counter lies inside the active instruction cache |
| ramEnable | input | 1 | Coprocessor owns the work RAM bus |
| romEnable | input | 1 | Coprocessor owns the ROM bus |
| startValid | output | 1 | Result of the last evaluation, held |
| goClear | output | 1 | One-cycle request to clear the run flag |
| evalDone | output | 1 | Results were updated this cycle |
| physAddr | output | 23 | Physical page in bits [22:16], counter in [15:0] |
| selRam | output | 1 | physAddr refers to work RAM instead of ROM |

## Verification
A wrong bank classification or a wrong enable selection would show directly as a wrong `startValid`, and as a missing or spurious `goClear`. Both are visible in the single cycle after the request. A wrong lookup entry, or a mistake in the bank-count limit, would show as a wrong page in `physAddr[22:16]` in that same cycle. Catching these errors needs banks that straddle each region edge (0x3F/0x40, 0x5F/0x60, 0x6F/0x70, 0x73/0x74, 0x7F/0x80), and more than one bank-count configuration. Faulty hold logic would show as outputs that change in cycles without a request.

// File: rtl/pfbPkg.sv
package pfbPkg;
  localparam int BANK_W = 8;
  localparam int PC_W   = 16;
  localparam int PAGE_W = 7;                 // enough for 0x20 + 63
  localparam int ADDR_W = PAGE_W + PC_W;
  localparam int ROM_CAP = 32;
  localparam int LOW_ROM_BASE = 32;          // low ROM window starts at page 0x20
  localparam int RAM_SLOTS = 4;

  typedef enum logic [1:0] {
    CLS_ROM  = 2'd0,
    CLS_RAM  = 2'd1,
    CLS_HOLE = 2'd2
  } bankCls_e;

  typedef struct packed {
    logic latch;     // capture mapped address
    logic refused;   // evaluation produced an invalid start
  } pfbStrobe_t;
endpackage

// File: rtl/pfbCtrl.sv
module pfbCtrl
  import pfbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       cacheHit,
  input  logic       ramEnable,
  input  logic       romEnable,
  input  bankCls_e   bankCls,
  output pfbStrobe_t strobe,
  output logic       startValid,
  output logic       goClear,
  output logic       evalDone
);
  logic allowed;

  always_comb begin
    if (cacheHit) allowed = 1'b1;
    else begin
      unique case (bankCls)
        CLS_RAM: allowed = ramEnable;
        CLS_ROM: allowed = romEnable;
        default: allowed = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.latch   = startPulse;
    strobe.refused = startPulse & ~allowed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startValid <= 1'b0;
      goClear    <= 1'b0;
      evalDone   <= 1'b0;
    end else begin
      evalDone <= startPulse;
      goClear  <= strobe.refused;
      if (startPulse) startValid <= allowed;
    end
  end

  // R1: cache hit always wins
  p_cache_wins_r1: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && cacheHit) |=> startValid);
  // R2: holes refuse without cache hit
  p_hole_refused_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !cacheHit && bankCls == CLS_HOLE) |=> (!startValid && goClear));
  // R5: clear request only right after an evaluation
  p_clear_after_eval_r5: assert property (@(posedge clk) disable iff (!rstN)
    goClear |-> (evalDone && !startValid));
  // R6: results hold without a request
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !startPulse |=> ($stable(startValid) && !evalDone && !goClear));
endmodule

// File: rtl/pfbMap.sv
module pfbMap
  import pfbPkg::*;
#(
  parameter int ROM_BANKS = 40,
  parameter int RAM_BANKS = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pfbStrobe_t          strobe,
  input  logic [BANK_W-1:0]   progBank,
  input  logic [PC_W-1:0]     progCounter,
  output bankCls_e            bankCls,
  output logic [ADDR_W-1:0]   physAddr,
  output logic                selRam
);
  localparam int ROM_REQ = (ROM_BANKS < 1) ? 1 : ROM_BANKS;
  localparam int ROM_EFF = (ROM_REQ > ROM_CAP) ? ROM_CAP : ROM_REQ;
  localparam int RAM_EFF = (RAM_BANKS < 1) ? 1 : RAM_BANKS;
  localparam int LUT_N   = 1 << (BANK_W - 1);
  localparam int HALF    = LUT_N / 2;

  logic [PAGE_W-1:0] romLut [LUT_N];
  logic [PAGE_W-1:0] ramLut [RAM_SLOTS];

  for (genvar i = 0; i < LUT_N; i++) begin : g_rom
    if (i >= HALF) begin : g_hi
      if (ROM_EFF > 1) begin : g_mod
        assign romLut[i] = PAGE_W'(i % ROM_EFF);
      end else begin : g_bit
        assign romLut[i] = PAGE_W'(i & 1);
      end
    end else begin : g_lo
      assign romLut[i] = PAGE_W'((i % (2 * ROM_EFF)) + LOW_ROM_BASE);
    end
  end

  for (genvar k = 0; k < RAM_SLOTS; k++) begin : g_ram
    assign ramLut[k] = PAGE_W'(k % RAM_EFF);
  end

  logic isRam, isHole;
  always_comb begin
    isRam  = (progBank[BANK_W-1:2] == 6'b011100);
    isHole = ((progBank < 8'h40) && !progCounter[PC_W-1])
           || (progBank[BANK_W-1:4] == 4'h6)
           || (progBank >= 8'h74);
    if (isHole)     bankCls = CLS_HOLE;
    else if (isRam) bankCls = CLS_RAM;
    else            bankCls = CLS_ROM;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr <= '0;
      selRam   <= 1'b0;
    end else if (strobe.latch) begin
      selRam <= isRam;
      physAddr <= isRam ? {ramLut[progBank[1:0]], progCounter}
                        : {romLut[progBank[BANK_W-2:0]], progCounter};
    end
  end

  // R9: RAM pages stay inside fitted RAM
  p_ram_page_r9: assert property (@(posedge clk) disable iff (!rstN)
    selRam |-> (int'(physAddr[ADDR_W-1:PC_W]) < RAM_EFF));
  // R10: ROM pages stay inside the capped ROM span
  p_rom_page_r10: assert property (@(posedge clk) disable iff (!rstN)
    !selRam |-> (int'(physAddr[ADDR_W-1:PC_W]) < LOW_ROM_BASE + 2 * ROM_EFF));
  // R6: counter passes through on capture
  p_pc_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (physAddr[PC_W-1:0] == $past(progCounter)));
  // R6: no capture, no change
  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latch |=> ($stable(physAddr) && $stable(selRam)));
endmodule

// File: rtl/pfbGate.sv
module pfbGate
  import pfbPkg::*;
#(
  parameter int ROM_BANKS = 40,
  parameter int RAM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [7:0]        progBank,
  input  logic [15:0]       progCounter,
  input  logic              cacheHit,
  input  logic              ramEnable,
  input  logic              romEnable,
  output logic              startValid,
  output logic              goClear,
  output logic              evalDone,
  output logic [22:0]       physAddr,
  output logic              selRam
);
  pfbStrobe_t strobe;
  bankCls_e   bankCls;

  pfbCtrl u_ctrl (
    .clk, .rstN, .startPulse, .cacheHit, .ramEnable, .romEnable,
    .bankCls, .strobe, .startValid, .goClear, .evalDone
  );

  pfbMap #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS)) u_map (
    .clk, .rstN, .strobe, .progBank, .progCounter,
    .bankCls, .physAddr, .selRam
  );
endmodule

// File: tb/tb_pfbGate.sv
module tb_pfbGate;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rstN, startPulse, cacheHit, ramEnable, romEnable;
  logic [7:0]  progBank;
  logic [15:0] progCounter;
  logic        validA, clrA, doneA, ramA, validB, clrB, doneB, ramB;
  logic [22:0] addrA, addrB;

  pfbGate #(.ROM_BANKS(40), .RAM_BANKS(2)) dut (
    .clk, .rstN, .startPulse, .progBank, .progCounter, .cacheHit, .ramEnable, .romEnable,
    .startValid(validA), .goClear(clrA), .evalDone(doneA), .physAddr(addrA), .selRam(ramA));
  pfbGate #(.ROM_BANKS(1), .RAM_BANKS(3)) dutB (
    .clk, .rstN, .startPulse, .progBank, .progCounter, .cacheHit, .ramEnable, .romEnable,
    .startValid(validB), .goClear(clrB), .evalDone(doneB), .physAddr(addrB), .selRam(ramB));

  typedef struct packed {
    logic [7:0]  bank;
    logic [15:0] pc;
    logic        ch, ramEn, romEn, expValid, expRam;
    logic [23:0] expA, expB;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h208000, 24'h208000},
    '{8'h00, 16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h207FFF, 24'h207FFF},
    '{8'h00, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'h207FFF, 24'h207FFF},
    '{8'h3F, 16'h8001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 24'h5F8001, 24'h218001},
    '{8'h3F, 16'h8001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h5F8001, 24'h218001},
    '{8'h40, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h000000, 24'h000000},
    '{8'h5F, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h1F1234, 24'h011234},
    '{8'h60, 16'h1234, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h001234, 24'h001234},
    '{8'h6F, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h0FFFFF, 24'h01FFFF},
    '{8'h6F, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'h0FFFFF, 24'h01FFFF},
    '{8'h70, 16'h0010, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h000010, 24'h000010},
    '{8'h71, 16'h0010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 24'h010010, 24'h010010},
    '{8'h72, 16'hABCD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h00ABCD, 24'h02ABCD},
    '{8'h73, 16'hABCD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 24'h01ABCD, 24'h00ABCD},
    '{8'h74, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h148000, 24'h008000},
    '{8'hC5, 16'h9000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h059000, 24'h019000},
    '{8'hC5, 16'h9000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 24'h059000, 24'h019000},
    '{8'h7F, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h1F0000, 24'h010000},
    '{8'h80, 16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h207FFF, 24'h207FFF},
    '{8'h20, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 24'h408000, 24'h208000},
    '{8'h68, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 24'h080000, 24'h000000}
  };

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input bit pulse);
    @(negedge clk);
    progBank = v.bank; progCounter = v.pc; cacheHit = v.ch;
    ramEnable = v.ramEn; romEnable = v.romEn; startPulse = pulse;
  endtask

  task automatic checkVec(input vec_t v);
    chk("R1/R2/R3/R4 startValid A", 32'(validA), 32'(v.expValid));
    chk("R1/R2/R3/R4 startValid B", 32'(validB), 32'(v.expValid));
    chk("R5 goClear", 32'(clrA), 32'(!v.expValid));
    chk("R6 evalDone", 32'(doneA), 32'd1);
    chk("R3/R4 selRam", 32'(ramA), 32'(v.expRam));
    chk("R7/R8/R9/R10 physAddr A", 32'(addrA), 32'(v.expA));
    chk("R7/R8/R9 physAddr B", 32'(addrB), 32'(v.expB));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0; startPulse = 0; cacheHit = 0; ramEnable = 0; romEnable = 0;
    progBank = 8'h00; progCounter = 16'h0000;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 startValid", 32'(validA), 0);
    chk("R11 goClear", 32'(clrA), 0);
    chk("R11 evalDone", 32'(doneA), 0);
    chk("R11 physAddr/selRam", {8'd0, ramA, addrA}, 0);
    rstN = 1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      drive(VECS[i], 1'b0);
      checkVec(VECS[i]);
    end

    // R5: pulse lasts one cycle; R6: outputs hold with changed inputs, no request
    drive(VECS[1], 1'b1);
    drive(VECS[12], 1'b0);
    chk("R5 refused pulse", 32'(clrA), 1);
    @(negedge clk);
    chk("R5 pulse ends", 32'(clrA), 0);
    chk("R6 evalDone ends", 32'(doneA), 0);
    repeat (3) @(negedge clk);
    chk("R6 startValid held", 32'(validA), 0);
    chk("R6 physAddr held", 32'(addrA), 32'h207FFF);
    chk("R6 selRam held", 32'(ramA), 0);

    // R6: back-to-back requests
    drive(VECS[4], 1'b1);
    drive(VECS[1], 1'b1);
    chk("R6 first of pair", 32'(addrA), 32'h5F8001);
    chk("R6 first of pair valid", 32'(validA), 1);
    drive(VECS[1], 1'b0);
    chk("R6 second of pair", 32'(addrA), 32'h207FFF);
    chk("R6 second of pair valid", 32'(validA), 0);
    chk("R5 second of pair clear", 32'(clrA), 1);

    // R11: reset mid-run clears results
    @(negedge clk); rstN = 0;
    @(negedge clk);
    chk("R11 re-reset", {validA, clrA, doneA, ramA, addrA}, 0);
    rstN = 1;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule